// File: doc/BRIEF.md
# I2C Target Acknowledge Decision Unit

This block sits beside the byte engine of an I2C target. Each time the byte engine finishes receiving an address byte or a data byte, it raises a one-cycle strobe. The block answers with a single ACK or NACK verdict for that byte. The verdict depends on the state of the receive and transmit buffers and on one configuration bit that selects the refusal style.

When a write is addressed while the receive buffer still holds bytes, the write must be refused. With the configuration bit set, the refusal happens at the address byte and a sticky interrupt flag records it. With the bit clear, the address is accepted and every data byte that follows is refused. A read addressed while the transmit side has nothing ready is refused at its first address byte, whatever the configuration bit says. The address byte is the only place a target can turn a read away.

The verdict is a plain registered pulse with no ready signal. The byte engine must take it in the cycle it appears, so there is no back-pressure at either edge. Bus START and STOP indications end any data refusal, so each new transaction is judged afresh.

Top module: `i2c_tgt_ack_ctrl`

## Requirements
- R1: After reset, `dec_vld` and `irq_dnr` are 0 and no data refusal is pending, so a data byte after reset is ACKed.
- R2: A strobe on `addr_vld` or `data_vld` in cycle t gives `dec_vld`=1 in cycle t+1 only. `dec_addr` is 1 for an address verdict and 0 for a data verdict. `dec_nack`=1 means NACK.
- R3: An address byte with `addr_rw`=1 (read) and `addr_first`=1, seen while `tx_rdy`=0, is NACKed whatever `dnr_cfg` is, and it leaves `irq_dnr` unchanged.
- R4: An address byte with `addr_rw`=0 (write), seen while `rx_empty`=0 and `dnr_cfg`=1, is NACKed. If that byte also has `addr_first`=1, `irq_dnr` is set in the same cycle as the verdict.
- R5: An address byte with `addr_rw`=0, seen while `rx_empty`=0 and `dnr_cfg`=0, is ACKed and does not touch `irq_dnr`.
- R6: After a write address byte refused under R4 or R5, every data byte is NACKed until the refusal is cleared.
- R7: Any address byte or data byte that is not covered by R3 to R6 is ACKed.
- R8: A pulse on `bus_start` or `bus_stop` clears a pending data refusal. The values of `rx_empty` and `tx_rdy` while a data byte arrives have no effect on that byte's verdict.
- R9: `irq_dnr` stays at 1 until a cycle with `irq_clr`=1. If a set and a clear arrive in the same cycle, the flag stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_vld | input | 1 | One-cycle strobe: an address byte was received |
| addr_rw | input | 1 | Direction bit of that address byte (1 = read) |
| addr_first | input | 1 | The byte is the first address byte after START or repeated START |
| data_vld | input | 1 | One-cycle strobe: a data byte was received |
| rx_empty | input | 1 | Receive buffer empty |
| tx_rdy | input | 1 | Transmit side has data ready |
| dnr_cfg | input | 1 | 1: refuse at the address; 0: refuse only the data |
| bus_start | input | 1 | START or repeated START seen on the bus |
| bus_stop | input | 1 | STOP seen on the bus |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| dec_vld | output | 1 | Verdict valid, one cycle per byte |
| dec_nack | output | 1 | Verdict: 1 = NACK, 0 = ACK |
| dec_addr | output | 1 | Verdict belongs to an address byte |
| irq_dnr | output | 1 | Sticky flag: a write was refused at its address |

## Verification
The assertions assume that the byte engine never raises `addr_vld` and `data_vld` in the same cycle. They also assume that each strobe lasts one cycle, and that `bus_start` and `bus_stop` never coincide with a byte strobe. The bench keeps inside these limits by choosing one event per cycle: an address byte, a data byte, a START, a STOP or idle. The buffer status bits, the direction bit, the first-byte marker, the configuration bit and the clear pulse are drawn freely in every cycle. A directed opening covers each refusal path and the set/clear collision on the flag.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;
  typedef enum logic [1:0] {
    VERD_ACK       = 2'd0,
    VERD_NACK_RD   = 2'd1,
    VERD_NACK_WR   = 2'd2,
    VERD_NACK_DATA = 2'd3
  } verdict_e;
endpackage

// File: rtl/i2c_ack_policy.sv
module i2c_ack_policy
  import i2c_ack_pkg::*;
(
  input  logic     addr_vld,
  input  logic     addr_rw,
  input  logic     addr_first,
  input  logic     data_vld,
  input  logic     rx_empty,
  input  logic     tx_rdy,
  input  logic     dnr_cfg,
  input  logic     refuse_armed,
  output verdict_e verdict,
  output logic     arm_set,
  output logic     irq_set
);
  logic rd_block;
  logic wr_block;

  // Read refusal only possible at the first address byte; it outranks dnr_cfg.
  assign rd_block = addr_rw && addr_first && !tx_rdy;
  assign wr_block = !addr_rw && !rx_empty;

  always_comb begin
    verdict = VERD_ACK;
    arm_set = 1'b0;
    irq_set = 1'b0;
    if (addr_vld) begin
      if (rd_block) begin
        verdict = VERD_NACK_RD;
      end else if (wr_block) begin
        arm_set = 1'b1;
        if (dnr_cfg) begin
          verdict = VERD_NACK_WR;
          irq_set = addr_first;
        end
      end
    end else if (data_vld && refuse_armed) begin
      verdict = VERD_NACK_DATA;
    end
  end
endmodule

// File: rtl/i2c_ack_txn_state.sv
module i2c_ack_txn_state (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set,
  input  logic bus_start,
  input  logic bus_stop,
  output logic refuse_armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) refuse_armed <= 1'b0;
    else        refuse_armed <= (refuse_armed && !(bus_start || bus_stop)) || arm_set;
  end

  p_clear_on_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (refuse_armed && (bus_start || bus_stop) && !arm_set) |=> !refuse_armed);
  p_hold_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (refuse_armed && !bus_start && !bus_stop) |=> refuse_armed);
endmodule

// File: rtl/i2c_ack_flag.sv
module i2c_ack_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_req) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && clr_req) |=> flag);
endmodule

// File: rtl/i2c_tgt_ack_ctrl.sv
module i2c_tgt_ack_ctrl
  import i2c_ack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic addr_vld,
  input  logic addr_rw,
  input  logic addr_first,
  input  logic data_vld,
  input  logic rx_empty,
  input  logic tx_rdy,
  input  logic dnr_cfg,
  input  logic bus_start,
  input  logic bus_stop,
  input  logic irq_clr,
  output logic dec_vld,
  output logic dec_nack,
  output logic dec_addr,
  output logic irq_dnr
);
  verdict_e verdict;
  logic     arm_set;
  logic     irq_set;
  logic     refuse_armed;

  i2c_ack_policy u_policy (
    .addr_vld     (addr_vld),
    .addr_rw      (addr_rw),
    .addr_first   (addr_first),
    .data_vld     (data_vld),
    .rx_empty     (rx_empty),
    .tx_rdy       (tx_rdy),
    .dnr_cfg      (dnr_cfg),
    .refuse_armed (refuse_armed),
    .verdict      (verdict),
    .arm_set      (arm_set),
    .irq_set      (irq_set)
  );

  i2c_ack_txn_state u_txn (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm_set      (arm_set),
    .bus_start    (bus_start),
    .bus_stop     (bus_stop),
    .refuse_armed (refuse_armed)
  );

  i2c_ack_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (irq_set),
    .clr_req (irq_clr),
    .flag    (irq_dnr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld  <= 1'b0;
      dec_nack <= 1'b0;
      dec_addr <= 1'b0;
    end else begin
      dec_vld  <= addr_vld || data_vld;
      dec_nack <= (addr_vld || data_vld) && (verdict != VERD_ACK);
      dec_addr <= addr_vld;
    end
  end

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_vld && data_vld));
  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_vld && !data_vld) |=> !dec_vld);
  p_read_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && addr_rw && addr_first && !tx_rdy) |=> (dec_vld && dec_nack && dec_addr));
  p_dnr_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && !addr_rw && addr_first && !rx_empty && dnr_cfg) |=> (dec_nack && irq_dnr));
  p_addr_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && !addr_rw && !rx_empty && !dnr_cfg) |=> (dec_vld && !dec_nack));
  p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_dnr) |-> $past(addr_vld && !addr_rw && addr_first && !rx_empty && dnr_cfg));
endmodule

// File: tb/i2c_tgt_ack_ctrl_tb_top.sv
module i2c_tgt_ack_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_vld = 0, addr_rw = 0, addr_first = 0, data_vld = 0;
  logic rx_empty = 1, tx_rdy = 1, dnr_cfg = 0;
  logic bus_start = 0, bus_stop = 0, irq_clr = 0;
  logic dec_vld, dec_nack, dec_addr, irq_dnr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit    m_armed = 0;
  bit    e_vld = 0, e_nack = 0, e_addr = 0, e_irq = 0;
  string e_tag = "R1";

  always #2 clk = ~clk;

  i2c_tgt_ack_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr_rw(addr_rw),
    .addr_first(addr_first), .data_vld(data_vld), .rx_empty(rx_empty),
    .tx_rdy(tx_rdy), .dnr_cfg(dnr_cfg), .bus_start(bus_start),
    .bus_stop(bus_stop), .irq_clr(irq_clr), .dec_vld(dec_vld),
    .dec_nack(dec_nack), .dec_addr(dec_addr), .irq_dnr(irq_dnr)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // one cycle: compare last cycle's prediction, drive new inputs, predict
  task automatic step(input bit av, input bit rw, input bit fi, input bit dv,
                      input bit rxe, input bit txr, input bit dnr,
                      input bit sta, input bit sto, input bit clr, input bit rst);
    bit arm, iset;
    @(negedge clk);
    chk("R2", "dec_vld", dec_vld, e_vld);
    if (e_vld) begin
      chk(e_tag, "dec_nack", dec_nack, e_nack);
      chk("R2", "dec_addr", dec_addr, e_addr);
    end
    chk("R9", "irq_dnr", irq_dnr, e_irq);
    addr_vld = av; addr_rw = rw; addr_first = fi; data_vld = dv;
    rx_empty = rxe; tx_rdy = txr; dnr_cfg = dnr;
    bus_start = sta; bus_stop = sto; irq_clr = clr; rst_n = !rst;
    arm = 0; iset = 0;
    e_vld = av || dv; e_addr = av; e_nack = 0; e_tag = "R7";
    if (av) begin
      if (rw && fi && !txr) begin
        e_nack = 1; e_tag = "R3";
      end else if (!rw && !rxe) begin
        arm = 1;
        if (dnr) begin e_nack = 1; e_tag = "R4"; iset = fi; end
        else e_tag = "R5";
      end
    end else if (dv) begin
      e_nack = m_armed;
      e_tag = m_armed ? "R6" : "R8";
    end
    m_armed = (m_armed && !(sta || sto)) || arm;
    if (iset) e_irq = 1;
    else if (clr) e_irq = 0;
    if (rst) begin
      m_armed = 0; e_vld = 0; e_irq = 0; e_tag = "R1";
    end
  endtask

  task automatic idle();
    step(0,0,0,0,1,1,0,0,0,0,0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // reset phase; R1 state checked in following steps
    step(0,0,0,0,1,1,0,0,0,0,1);
    step(0,0,0,0,1,1,0,0,0,0,1);
    idle();
    chk("R1", "reset dec_vld", dec_vld, 1'b0);
    chk("R1", "reset irq", irq_dnr, 1'b0);
    // R7: normal write, data ACKed
    step(0,0,0,0,1,1,0,1,0,0,0);
    step(1,0,1,0,1,1,0,0,0,0,0);
    step(0,0,0,1,1,1,0,0,0,0,0);
    step(0,0,0,0,1,1,0,0,1,0,0);
    // R4: dnr refusal at address, flag set; R6 data NACK
    step(0,0,0,0,1,1,1,1,0,0,0);
    step(1,0,1,0,0,1,1,0,0,0,0);
    step(0,0,0,1,0,1,1,0,0,0,0);
    idle();
    // R9: set and clear together keeps flag; clear alone drops it
    step(1,0,1,0,0,1,1,0,0,1,0);
    idle();
    step(0,0,0,0,1,1,0,0,0,1,0);
    idle();
    // R5 / R6 / R8: refuse only data; rx status at data time ignored; stop clears
    step(0,0,0,0,1,1,0,1,0,0,0);
    step(1,0,1,0,0,1,0,0,0,0,0);
    step(0,0,0,1,0,1,0,0,0,0,0);
    step(0,0,0,1,1,0,0,0,0,0,0);
    step(0,0,0,0,1,1,0,0,1,0,0);
    step(0,0,0,1,0,0,0,0,0,0,0);
    // R3: read with tx not ready, dnr ignored, flag untouched
    step(1,1,1,0,0,0,1,0,0,0,0);
    step(1,1,1,0,1,1,1,0,0,0,0);
    step(1,1,0,0,1,0,0,0,0,0,0);
    idle();
    // R1: reset drops a pending refusal
    step(1,0,1,0,0,1,0,0,0,0,0);
    step(0,0,0,0,1,1,0,0,0,0,1);
    idle();
    step(0,0,0,1,0,1,0,0,0,0,0);
    idle();
    // random phase, one event per cycle
    for (int i = 0; i < 4000; i++) begin
      int ev;
      ev = $urandom % 8;
      step(ev < 3, $urandom % 2, $urandom % 2, ev >= 3 && ev < 6,
           $urandom % 2, $urandom % 2, $urandom % 2,
           ev == 6, ev == 7 && ($urandom % 2 == 1), ($urandom % 8) == 0, 0);
    end
    idle();
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule